// File: doc/BRIEF.md
# Dual-Bank Receive Endpoint Buffer

This block buffers the data of one bulk or interrupt OUT endpoint in two banks. Each bank holds one maximum-size packet. The USB side writes the bytes of a packet into a free bank. An end-of-packet strobe closes the bank and records how many bytes it holds. The CPU side works on a separate bank at the same time. It reads bytes one by one through a data port and then hands the bank back with a trigger strobe. The trigger also points the CPU side at the other bank. Packets therefore reach the CPU in the order they arrived, and the USB side is never held up while the CPU drains an earlier packet.

The CPU sees three things: a size value holding the byte count of its current bank, a ready flag that is high while that bank holds a finished packet, and a sticky error flag for reads past the end. A clear strobe throws away every buffered packet and resets the CPU read position. A packet the USB side is still receiving is not touched by the clear. When no bank is free, a busy output tells the USB side to refuse further data.

Top module: `rxPingPongFifo`

## Requirements
- R1: After reset, dataReady, rxSize, usbBusy and overreadErr are all 0.
- R2: Each byte accepted on usbValid is stored at the next position of the bank being filled. A usbEop strobe marks that bank full, with a count equal to the number of bytes accepted, including a byte given in the same cycle as usbEop. Bytes beyond MAX_PKT are dropped, so the count stops at MAX_PKT.
- R3: A usbEop with no bytes before it marks a bank full with a count of 0. This sets dataReady to 1 while rxSize stays 0.
- R4: cpuRdData always shows the byte at the current read position of the CPU bank. Each cpuRdEn pulse moves the read position on by one, so the bytes come out in the order they were written.
- R5: When the read position equals the bank count, or no packet is ready, cpuRdData shows 0. A cpuRdEn in that state does not move the position and sets overreadErr. overreadErr then stays at 1 until cpuClr.
- R6: A cpuTrig while dataReady is 1 frees the CPU bank, resets the read position and switches to the other bank. From the next cycle on, rxSize shows that bank's count, or 0 if the bank is empty. A cpuTrig while dataReady is 0 is ignored.
- R7: The USB side can fill one bank while the CPU holds the other. Back-to-back packets come out in arrival order.
- R8: usbBusy is 1 exactly when the bank the USB side would fill next is still full, that is, when both banks hold packets. Bytes and usbEop given while usbBusy is 1 are discarded.
- R9: cpuClr frees every bank that holds a finished packet and clears overreadErr. A packet that is partly received survives the clear and, once it ends, is delivered with all of its bytes. A USB event in the same cycle as cpuClr takes effect. cpuClr takes precedence over a cpuTrig in the same cycle.
- R10: dataReady is 1 exactly while the CPU bank holds a finished packet. rxSize is 0 whenever dataReady is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| usbValid | input | 1 | A received byte is present on usbData |
| usbData | input | DW | Received byte |
| usbEop | input | 1 | End-of-packet strobe; closes the bank being filled |
| usbBusy | output | 1 | No free bank; the USB side must refuse data |
| cpuRdEn | input | 1 | Consume the byte shown on cpuRdData |
| cpuRdData | output | DW | Byte at the current read position, 0 when not valid |
| cpuTrig | input | 1 | Release the current bank and switch banks |
| cpuClr | input | 1 | Discard buffered packets |
| rxSize | output | $clog2(MAX_PKT+1) | Byte count of the CPU bank |
| dataReady | output | 1 | CPU bank holds a finished packet |
| overreadErr | output | 1 | Sticky flag for a read past the valid count |

## Verification
The tests cover:
- a single short packet, and two packets back to back with no read in between;
- a zero-length packet, and an oversize packet that runs past the bank;
- reads that run past the end;
- a clear that arrives while a packet is only partly received.

The back-to-back case makes sure the bank order is correct: the second packet must not show up first, and the bytes of the two packets must not mix. It also checks that usbBusy drops data. The zero-length and oversize packets test both ends of the byte count. The overread case tells a reader that stops at the count apart from one that wraps or moves past it. The clear case tells a clear that protects the bank being filled apart from one that wipes everything.

// File: rtl/rxFifoPkg.sv
package rxFifoPkg;
  localparam int NUM_BANKS = 2;

  // Strobes from the control module to the bank storage
  typedef struct packed {
    logic wrEn;     // write one byte into the fill bank
    logic wrBank;   // bank being filled
    logic rdBank;   // bank owned by the CPU side
    logic rdValid;  // read position holds valid data
  } fifoStrb_t;
endpackage

// File: rtl/rxFifoData.sv
module rxFifoData
  import rxFifoPkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int DW      = 8,
  parameter int AW      = $clog2(MAX_PKT)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrb_t     strb,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0] bankOut [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic [DW-1:0] mem [MAX_PKT];
    always_ff @(posedge clk) begin
      if (strb.wrEn && (strb.wrBank == 1'(b)))
        mem[wrAddr] <= wrData;
    end
    assign bankOut[b] = mem[rdAddr];
  end

  assign rdData = strb.rdValid ? bankOut[strb.rdBank] : '0;

  // R5: an invalid read position never exposes stored data
  assert_rd_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdValid |-> (rdData == '0));
endmodule

// File: rtl/rxFifoCtrl.sv
module rxFifoCtrl
  import rxFifoPkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int AW      = $clog2(MAX_PKT),
  parameter int CW      = $clog2(MAX_PKT + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          usbValid,
  input  logic          usbEop,
  output logic          usbBusy,
  input  logic          cpuRdEn,
  input  logic          cpuTrig,
  input  logic          cpuClr,
  output logic [CW-1:0] rxSize,
  output logic          dataReady,
  output logic          overreadErr,
  output fifoStrb_t     strb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr
);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_PKT);

  logic [NUM_BANKS-1:0] bankFull;
  logic [CW-1:0]        bankCnt [NUM_BANKS];
  logic                 wrBank, rdBank, usbActive, overErr;
  logic [CW-1:0]        wrCnt, rdPtr;

  logic          acceptByte, acceptEop, curFull, rdOk, doTrig;
  logic [CW-1:0] curCnt, closeCnt;

  always_comb begin
    usbBusy    = bankFull[wrBank];
    acceptByte = usbValid && !usbBusy && (wrCnt < CNT_MAX);
    acceptEop  = usbEop && !usbBusy;
    closeCnt   = wrCnt + CW'(acceptByte);
    curFull    = bankFull[rdBank];
    curCnt     = bankCnt[rdBank];
    rdOk       = curFull && (rdPtr < curCnt);
    doTrig     = cpuTrig && curFull && !cpuClr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankFull  <= '0;
      for (int b = 0; b < NUM_BANKS; b++) bankCnt[b] <= '0;
      wrBank    <= 1'b0;
      rdBank    <= 1'b0;
      usbActive <= 1'b0;
      overErr   <= 1'b0;
      wrCnt     <= '0;
      rdPtr     <= '0;
    end else begin
      // CPU side first; the USB event below overrides on its own bank
      if (cpuClr) begin
        bankFull <= '0;
        for (int b = 0; b < NUM_BANKS; b++) bankCnt[b] <= '0;
        rdBank   <= wrBank;
        rdPtr    <= '0;
        overErr  <= 1'b0;
      end else begin
        if (doTrig) begin
          bankFull[rdBank] <= 1'b0;
          rdBank           <= ~rdBank;
          rdPtr            <= '0;
        end else if (cpuRdEn && rdOk) begin
          rdPtr <= rdPtr + 1'b1;
        end
        if (cpuRdEn && !rdOk && !doTrig) overErr <= 1'b1;
      end

      if (acceptByte) begin
        wrCnt     <= wrCnt + 1'b1;
        usbActive <= 1'b1;
      end
      if (acceptEop) begin
        bankFull[wrBank] <= 1'b1;
        bankCnt[wrBank]  <= closeCnt;
        wrBank           <= ~wrBank;
        wrCnt            <= '0;
        usbActive        <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.wrEn    = acceptByte;
    strb.wrBank  = wrBank;
    strb.rdBank  = rdBank;
    strb.rdValid = rdOk;
    wrAddr       = wrCnt[AW-1:0];
    rdAddr       = rdPtr[AW-1:0];
    rxSize       = curFull ? curCnt : '0;
    dataReady    = curFull;
    overreadErr  = overErr;
  end

  // R8: no byte is stored while the fill bank is still occupied
  assert_no_write_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    usbBusy |-> !strb.wrEn);
  // R2: the fill position never passes one bank
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrCnt <= CNT_MAX);
  // R5: a rejected read leaves the read position unchanged
  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdEn && !rdOk && !cpuTrig && !cpuClr) |=> $stable(rdPtr));
  // R5: the error flag is sticky until a clear
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (overErr && !cpuClr) |=> overErr);
  // R6: a trigger on a ready bank switches the CPU side
  assert_trig_swap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuTrig && curFull && !cpuClr) |=> (rdBank != $past(rdBank)) && (rdPtr == '0));
  // R9: a clear leaves a partly received packet in progress
  assert_clr_keeps_fill_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClr && usbActive && !usbEop) |=> usbActive && (wrCnt >= $past(wrCnt)));
endmodule

// File: rtl/rxPingPongFifo.sv
module rxPingPongFifo
  import rxFifoPkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int DW      = 8,
  localparam int AW     = $clog2(MAX_PKT),
  localparam int CW     = $clog2(MAX_PKT + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          usbValid,
  input  logic [DW-1:0] usbData,
  input  logic          usbEop,
  output logic          usbBusy,
  input  logic          cpuRdEn,
  output logic [DW-1:0] cpuRdData,
  input  logic          cpuTrig,
  input  logic          cpuClr,
  output logic [CW-1:0] rxSize,
  output logic          dataReady,
  output logic          overreadErr
);
  fifoStrb_t     strb;
  logic [AW-1:0] wrAddr, rdAddr;

  rxFifoCtrl #(.MAX_PKT(MAX_PKT), .AW(AW), .CW(CW)) uCtrl (
    .clk(clk), .rstN(rstN),
    .usbValid(usbValid), .usbEop(usbEop), .usbBusy(usbBusy),
    .cpuRdEn(cpuRdEn), .cpuTrig(cpuTrig), .cpuClr(cpuClr),
    .rxSize(rxSize), .dataReady(dataReady), .overreadErr(overreadErr),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  rxFifoData #(.MAX_PKT(MAX_PKT), .DW(DW), .AW(AW)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .wrData(usbData),
    .rdAddr(rdAddr), .rdData(cpuRdData)
  );

  // R10: no size is shown without a ready packet
  assert_size_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
    !dataReady |-> (rxSize == '0));
endmodule

// File: tb/sim_rxPingPongFifo.sv
`timescale 1ns/1ps
module sim_rxPingPongFifo;
  localparam int MAX_PKT = 64;
  localparam int DW = 8;
  localparam int CW = $clog2(MAX_PKT + 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic usbValid = 0, usbEop = 0, cpuRdEn = 0, cpuTrig = 0, cpuClr = 0;
  logic [DW-1:0] usbData = '0;
  logic usbBusy, dataReady, overreadErr;
  logic [DW-1:0] cpuRdData;
  logic [CW-1:0] rxSize;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rxPingPongFifo #(.MAX_PKT(MAX_PKT), .DW(DW)) u0 (
    .clk(clk), .rstN(rstN), .usbValid(usbValid), .usbData(usbData),
    .usbEop(usbEop), .usbBusy(usbBusy), .cpuRdEn(cpuRdEn),
    .cpuRdData(cpuRdData), .cpuTrig(cpuTrig), .cpuClr(cpuClr),
    .rxSize(rxSize), .dataReady(dataReady), .overreadErr(overreadErr)
  );

  task automatic cycle();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pushByte(logic [7:0] d);
    usbValid = 1; usbData = d; cycle(); usbValid = 0;
  endtask

  task automatic endPkt();
    usbEop = 1; cycle(); usbEop = 0;
  endtask

  task automatic sendPkt(int n, int base);
    for (int i = 0; i < n; i++) pushByte(8'(base + i));
    endPkt();
  endtask

  task automatic readByte(string req, int exp);
    chk(req, int'(cpuRdData), exp);
    cpuRdEn = 1; cycle(); cpuRdEn = 0;
  endtask

  task automatic trig();
    cpuTrig = 1; cycle(); cpuTrig = 0;
  endtask

  task automatic clr();
    cpuClr = 1; cycle(); cpuClr = 0;
  endtask

  task automatic testReset();
    chk("R1 dataReady", dataReady, 0);
    chk("R1 rxSize", rxSize, 0);
    chk("R1 usbBusy", usbBusy, 0);
    chk("R1 overreadErr", overreadErr, 0);
  endtask

  task automatic testSingle();
    sendPkt(5, 8'h10);
    chk("R2 dataReady", dataReady, 1);
    chk("R2 rxSize", rxSize, 5);
    for (int i = 0; i < 5; i++) readByte("R4 byte order", 8'h10 + i);
    chk("R5 no error on exact read", overreadErr, 0);
    trig();
    chk("R6 released", dataReady, 0);
    chk("R10 size zero", rxSize, 0);
  endtask

  task automatic testBackToBack();
    sendPkt(3, 8'h40);
    sendPkt(4, 8'h80);
    chk("R8 busy when both full", usbBusy, 1);
    pushByte(8'hEE); endPkt();       // R8: discarded
    chk("R7 first packet size", rxSize, 3);
    for (int i = 0; i < 3; i++) readByte("R7 first packet", 8'h40 + i);
    trig();
    chk("R6 size of next bank", rxSize, 4);
    chk("R8 busy released", usbBusy, 0);
    for (int i = 0; i < 4; i++) readByte("R7 second packet", 8'h80 + i);
    trig();
    chk("R8 dropped packet absent", dataReady, 0);
  endtask

  task automatic testOverread();
    readByte("R5 empty reads zero", 0);
    chk("R5 flag on empty read", overreadErr, 1);
    clr();
    chk("R9 clear drops flag", overreadErr, 0);
    trig();                           // R6: ignored, nothing ready
    chk("R6 trig ignored", dataReady, 0);
    sendPkt(2, 8'hA0);
    readByte("R5 data", 8'hA0);
    readByte("R5 data", 8'hA1);
    readByte("R5 overread zero", 0);
    chk("R5 sticky flag", overreadErr, 1);
    chk("R5 size kept", rxSize, 2);
    chk("R5 still zero", cpuRdData, 0);
    trig();
    sendPkt(2, 8'hB0);
    chk("R5 flag stays set", overreadErr, 1);
    readByte("R6 pointer reset", 8'hB0);
    readByte("R6 pointer reset", 8'hB1);
    trig();
    clr();
  endtask

  task automatic testZeroLen();
    endPkt();
    chk("R3 ready", dataReady, 1);
    chk("R3 size zero", rxSize, 0);
    chk("R3 data zero", cpuRdData, 0);
    trig();
    chk("R3 released", dataReady, 0);
  endtask

  task automatic testSaturate();
    for (int i = 0; i < MAX_PKT + 2; i++) pushByte(8'(i));
    endPkt();
    chk("R2 count capped", rxSize, MAX_PKT);
    for (int i = 0; i < MAX_PKT; i++) readByte("R2 capped data", i);
    chk("R2 past cap zero", cpuRdData, 0);
    trig();
    // byte given in the same cycle as usbEop is included (R2)
    pushByte(8'h31);
    usbValid = 1; usbData = 8'h32; usbEop = 1; cycle();
    usbValid = 0; usbEop = 0;
    chk("R2 eop byte counted", rxSize, 2);
    readByte("R2 eop byte", 8'h31);
    readByte("R2 eop byte", 8'h32);
    trig();
  endtask

  task automatic testClearWhileFilling();
    sendPkt(3, 8'h20);                // finished packet to be dropped
    pushByte(8'h60); pushByte(8'h61); // packet in progress
    clr();
    chk("R9 finished packet dropped", dataReady, 0);
    chk("R9 busy low", usbBusy, 0);
    pushByte(8'h62); endPkt();
    chk("R9 in-progress size", rxSize, 3);
    for (int i = 0; i < 3; i++) readByte("R9 in-progress data", 8'h60 + i);
    trig();
    chk("R9 nothing left", dataReady, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #35 rstN = 1'b1;
    cycle();
    testReset();
    testSingle();
    testBackToBack();
    testOverread();
    testZeroLen();
    testSaturate();
    testClearWhileFilling();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule